// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block decides which on-chip peripheral interrupt request starts a transfer on each of four DMA channels. Each channel owns an 8-bit trigger register. Bits 5:0 hold a source number and bit 7 holds a sticky pending-request flag. When a rising edge appears on the interrupt line that a channel selects, that channel's flag is latched. The flag then raises the channel's start request toward the DMA engine. The flag is cleared by the engine's per-channel acknowledge, by software, or by the channel's init/stop input.

Software reaches the registers through a small write port that supports two kinds of access. A full-byte write loads both the flag and the source number. A single-bit write can only change the flag. Reads come back one cycle later from a registered read port. While the device is in standby, edges are still latched into the flags but the start requests are held back. The held requests appear on the first cycle after standby ends.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset all four registers read 0x00 and every start request output is 0.
- R2: A byte write (`wr_single_i`=0) loads bit 7 into the flag and bits 5:0 into the source number. Bit 6 always reads 0. `rd_data_o` shows the register selected by `rd_ch_i` at the previous clock edge, one cycle after that register changed.
- R3: A single-bit write (`wr_single_i`=1) with `wr_pos_i`=7 sets the flag to `wr_data_i[0]`. A single-bit write to any position 0 to 6 leaves the register unchanged.
- R4: A source number v from 1 to 63 selects `irq_i[v-1]`. A 0-to-1 transition on that line sets the flag at the next clock edge. A line that stays high does not set the flag again after it has been cleared.
- R5: Source number 0 selects no line, so the flag is never set by any interrupt activity.
- R6: Channels that select the same source all set their flags from one rising edge of that line.
- R7: `ack_i[c]` clears the flag of channel c. If a rising edge (or a software set) and a clear (acknowledge or software write of 0) fall in the same cycle, the flag ends at 1.
- R8: While `init_i[c]` is high, the flag of channel c is forced to 0, even against a selected rising edge.
- R9: `start_req_o[c]` is registered. It is high after an edge exactly when the flag being loaded at that edge is 1 and `en_i[c]` was high. Dropping `en_i[c]` masks the output but leaves the flag set.
- R10: While `standby_i` is high, rising edges are still latched into the flags but every start request is 0. Pending requests appear on the first edge after `standby_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 63 | Peripheral interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_single_i | input | 1 | 1 = single-bit access, 0 = full-byte access |
| wr_ch_i | input | 2 | Channel addressed by the write |
| wr_pos_i | input | 3 | Bit position for a single-bit access |
| wr_data_i | input | 8 | Byte data; bit 0 is the value for a single-bit access |
| rd_ch_i | input | 2 | Channel to read |
| rd_data_o | output | 8 | Registered read data |
| en_i | input | 4 | Per-channel enable from the DMA engine |
| init_i | input | 4 | Per-channel init/stop, clears the flag |
| ack_i | input | 4 | Per-channel transfer acknowledge, clears the flag |
| standby_i | input | 1 | Standby mode, masks start requests |
| start_req_o | output | 4 | Per-channel transfer start request |

## Verification
Two events can land on the same flag in the same cycle: a rising edge on the selected interrupt line, and a clear from the engine's acknowledge or from a software write of 0. The bench provokes this by driving the interrupt line high at the same falling edge where it drives the acknowledge or the single-bit write of 0. The flag is judged correct only if it reads 1 afterwards. The same method pits init/stop against a rising edge, and there the flag must read 0.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 6;
  localparam int FLAG_BIT = 7;
  localparam int POS_W    = 3;

  typedef struct packed {
    logic             flag;
    logic [SEL_W-1:0] src;
  } chan_reg_t;

  function automatic logic [REG_W-1:0] pack_reg(chan_reg_t r);
    return {r.flag, 1'b0, r.src};
  endfunction
endpackage

// File: rtl/dts_edge.sv
module dts_edge #(
  parameter int NIRQ = 63
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq_i,
  output logic [NIRQ:0]   rise_o
);
  logic [NIRQ-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_i;
  end

  // Index 0 is the "no source" slot and never fires.
  assign rise_o = {irq_i & ~irq_q, 1'b0};
endmodule

// File: rtl/dts_chan.sv
module dts_chan
  import dts_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  rise_i,
  input  logic             byte_we_i,
  input  logic             bit_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             en_i,
  input  logic             init_i,
  input  logic             ack_i,
  input  logic             standby_i,
  output chan_reg_t        reg_o,
  output logic             start_o
);
  chan_reg_t r_q;
  logic      start_q;
  logic      hit, sw_set, sw_clr, flag_nxt;

  assign hit    = rise_i[r_q.src];
  assign sw_set = (byte_we_i & wdata_i[FLAG_BIT]) | (bit_we_i & wdata_i[0]);
  assign sw_clr = (byte_we_i & ~wdata_i[FLAG_BIT]) | (bit_we_i & ~wdata_i[0]);

  always_comb begin
    if (init_i)                flag_nxt = 1'b0;
    else if (hit || sw_set)    flag_nxt = 1'b1;
    else if (ack_i || sw_clr)  flag_nxt = 1'b0;
    else                       flag_nxt = r_q.flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q     <= '0;
      start_q <= 1'b0;
    end else begin
      r_q.flag <= flag_nxt;
      if (byte_we_i) r_q.src <= wdata_i[SEL_W-1:0];
      start_q  <= flag_nxt & en_i & ~standby_i;
    end
  end

  assign reg_o   = r_q;
  assign start_o = start_q;

  a_r4_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (hit && !init_i) |=> r_q.flag);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !hit && !byte_we_i && !bit_we_i && !init_i) |=> !r_q.flag);
  a_r8_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_i |=> !r_q.flag);
  a_r9_start_needs_en: assert property (@(posedge clk) disable iff (rst)
    start_q |-> ($past(en_i) && r_q.flag));
  a_r10_standby_masks: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !$past(standby_i));
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dts_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NIRQ = 63,
  localparam int CHW  = $clog2(NCH),
  localparam int NSRC = NIRQ + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             wr_en_i,
  input  logic             wr_single_i,
  input  logic [CHW-1:0]   wr_ch_i,
  input  logic [POS_W-1:0] wr_pos_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [CHW-1:0]   rd_ch_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [NCH-1:0]   en_i,
  input  logic [NCH-1:0]   init_i,
  input  logic [NCH-1:0]   ack_i,
  input  logic             standby_i,
  output logic [NCH-1:0]   start_req_o
);
  logic [NSRC-1:0] rise;
  chan_reg_t       regs [NCH];
  logic [REG_W-1:0] rd_q;

  dts_edge #(.NIRQ(NIRQ)) u_edge (
    .clk(clk), .rst(rst), .irq_i(irq_i), .rise_o(rise)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_ch, byte_we, bit_we;
    assign hit_ch  = wr_en_i && (wr_ch_i == CHW'(c));
    assign byte_we = hit_ch && !wr_single_i;
    assign bit_we  = hit_ch && wr_single_i && (wr_pos_i == POS_W'(FLAG_BIT));

    dts_chan #(.NSRC(NSRC)) u_chan (
      .clk(clk), .rst(rst), .rise_i(rise),
      .byte_we_i(byte_we), .bit_we_i(bit_we), .wdata_i(wr_data_i),
      .en_i(en_i[c]), .init_i(init_i[c]), .ack_i(ack_i[c]),
      .standby_i(standby_i), .reg_o(regs[c]), .start_o(start_req_o[c])
    );

    a_r3_bit_write_keeps_src: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && wr_single_i) |=> $stable(regs[c].src));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= pack_reg(regs[rd_ch_i]);
  end
  assign rd_data_o = rd_q;
endmodule

// File: tb/dma_trig_sel_bench.sv
module dma_trig_sel_bench;
  logic        clk = 0, rst = 1;
  logic [62:0] irq = '0;
  logic        wr_en = 0, wr_single = 0;
  logic [1:0]  wr_ch = 0, rd_ch = 0;
  logic [2:0]  wr_pos = 0;
  logic [7:0]  wr_data = 0, rd_data;
  logic [3:0]  en = 0, init = 0, ack = 0, start;
  logic        standby = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_trig_sel u_dma_trig_sel (
    .clk(clk), .rst(rst), .irq_i(irq), .wr_en_i(wr_en), .wr_single_i(wr_single),
    .wr_ch_i(wr_ch), .wr_pos_i(wr_pos), .wr_data_i(wr_data), .rd_ch_i(rd_ch),
    .rd_data_o(rd_data), .en_i(en), .init_i(init), .ack_i(ack),
    .standby_i(standby), .start_req_o(start)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic wbyte(input int ch, input logic [7:0] d);
    wr_en = 1; wr_single = 0; wr_ch = 2'(ch); wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic wbit(input int ch, input int pos, input logic v);
    wr_en = 1; wr_single = 1; wr_ch = 2'(ch); wr_pos = 3'(pos); wr_data = {7'd0, v};
    tick(); wr_en = 0; wr_single = 0;
  endtask

  task automatic rd(input int ch, output logic [7:0] d);
    rd_ch = 2'(ch); tick(); d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int c = 0; c < 4; c++) begin rd(c, d); chk("R1 reg reset", d, 8'h00); end
    chk("R1 start reset", {4'd0, start}, 8'h00);
  endtask

  task automatic t_byte;
    logic [7:0] d;
    wbyte(1, 8'hC5); rd(1, d); chk("R2 byte write, bit6 zero", d, 8'h85);
    wbyte(1, 8'h05); rd(1, d); chk("R2 byte clear flag", d, 8'h05);
  endtask

  task automatic t_single;
    logic [7:0] d;
    wbit(1, 3, 1'b0); rd(1, d); chk("R3 single bit to src ignored", d, 8'h05);
    wbit(1, 6, 1'b1); rd(1, d); chk("R3 single bit 6 ignored", d, 8'h05);
    wbit(1, 7, 1'b1); rd(1, d); chk("R3 single bit sets flag", d, 8'h85);
    wbit(1, 7, 1'b0); rd(1, d); chk("R3 single bit clears flag", d, 8'h05);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wbyte(0, 8'h03);
    irq[2] = 1; tick(); rd(0, d); chk("R4 edge sets flag", d, 8'h83);
    wbit(0, 7, 1'b0); tick(); tick(); rd(0, d); chk("R4 level no retrigger", d, 8'h03);
    irq[2] = 0; tick();
    irq[4] = 1; tick(); irq[4] = 0; rd(0, d); chk("R4 other line ignored", d, 8'h03);
  endtask

  task automatic t_zero;
    logic [7:0] d;
    irq = '1; tick(); irq = '0; tick(); rd(2, d); chk("R5 source 0 never fires", d, 8'h00);
    for (int c = 0; c < 2; c++) wbit(c, 7, 1'b0);
  endtask

  task automatic t_shared;
    logic [7:0] d;
    wbyte(0, 8'h0A); wbyte(3, 8'h0A);
    irq[9] = 1; tick(); irq[9] = 0;
    rd(0, d); chk("R6 shared ch0", d, 8'h8A);
    rd(3, d); chk("R6 shared ch3", d, 8'h8A);
    rd(1, d); chk("R6 unselected ch1", d, 8'h05);
  endtask

  task automatic t_enable_ack;
    logic [7:0] d;
    en = 4'b0001; tick(); chk("R9 start with en", {7'd0, start[0]}, 8'h01);
    en = 4'b0000; tick(); chk("R9 en masks", {7'd0, start[0]}, 8'h00);
    rd(0, d); chk("R9 flag kept", d, 8'h8A);
    en = 4'b0001; ack[0] = 1; tick(); ack[0] = 0;
    chk("R7 ack drops start", {7'd0, start[0]}, 8'h00);
    rd(0, d); chk("R7 ack clears", d, 8'h0A);
    irq[9] = 1; ack[0] = 1; tick(); ack[0] = 0; irq[9] = 0;
    rd(0, d); chk("R7 set wins over ack", d, 8'h8A);
    wbit(0, 7, 1'b0);
    irq[9] = 1; wr_en = 1; wr_single = 1; wr_ch = 0; wr_pos = 7; wr_data = 0;
    tick(); wr_en = 0; wr_single = 0; irq[9] = 0;
    rd(0, d); chk("R7 set wins over sw clear", d, 8'h8A);
    wbit(0, 7, 1'b0); wbit(3, 7, 1'b0); en = 0;
  endtask

  task automatic t_init;
    logic [7:0] d;
    init[3] = 1; irq[9] = 1; tick(); init[3] = 0; irq[9] = 0;
    rd(3, d); chk("R8 init beats edge", d, 8'h0A);
    wbit(0, 7, 1'b0);
  endtask

  task automatic t_standby;
    logic [7:0] d;
    en = 4'b1111; standby = 1;
    irq[9] = 1; tick(); irq[9] = 0; tick();
    chk("R10 masked in standby", {4'd0, start}, 8'h00);
    rd(0, d); chk("R10 edge held", d, 8'h8A);
    standby = 0; tick();
    chk("R10 presented after wake", {4'd0, start}, 8'h09);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_byte(); t_single(); t_edge(); t_zero();
        t_shared(); t_enable_ack(); t_init(); t_standby();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule